// File: doc/BRIEF.md
# Single-Precision Float Comparator

This block orders two 32-bit single-precision floating-point words. A one-cycle input strobe qualifies the pair. One clock later the block raises an output strobe together with one of four flags: less-than, equal, greater-than or unordered. The flags stay unchanged until the next strobed pair arrives, so a consumer can sample them at any later time.

The encoding keeps the sign in the top bit. Below it are the biased exponent and then the stored fraction. Because of this layout, the block never decodes the numbers arithmetically. For two values of the same sign, the exponent and fraction taken together as one unsigned integer already follow magnitude order. The sign then picks the direction of the result. Zeros are reduced to a single canonical form before the integer compare, so that positive and negative zero fall together. Not-a-number operands bypass the ordering and report unordered.

Top module: `fcmp_top`

## Requirements
- R1: A word with bit 31 set is negative. When the operands differ in sign and neither is NaN, the negative operand is the smaller one. A zero operand counts as non-negative for this rule.
- R2: When both operands are positive and non-zero, the result follows the unsigned integer order of bits 30..0. The exponent (bits 30..23, biased by 127) decides first, and the fraction (bits 22..0) breaks ties.
- R3: When both operands are negative and non-zero, the result is the reverse of the unsigned order of bits 30..0.
- R4: Any operand whose exponent field (bits 30..23) is 0 is the value zero, whatever its sign and fraction. Two such operands compare equal. A zero is greater than every negative non-zero operand and less than every positive non-zero operand.
- R5: An operand with exponent field 255 and a non-zero fraction is NaN. If either operand is NaN, only the unordered flag is set. An exponent of 255 with a zero fraction is infinity, and it orders above every finite value of its sign.
- R6: Whenever the output strobe is high, exactly one of lt, eq, gt and unord is high.
- R7: The output strobe is high in exactly the cycle that follows a cycle with the input strobe high, and the result is present in that same cycle.
- R8: In a cycle with the input strobe low, the operand inputs are ignored and the four flags keep their previous values.
- R9: When rst_n is low at a clock edge, the output strobe and all four flags are 0 after that edge.
- R10: Two identical operand words that are not NaN compare equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Qualifies opa and opb in this cycle |
| opa | input | 32 | Left operand |
| opb | input | 32 | Right operand |
| out_vld | output | 1 | Result strobe, one cycle after in_vld |
| lt | output | 1 | opa is less than opb |
| eq | output | 1 | opa equals opb |
| gt | output | 1 | opa is greater than opb |
| unord | output | 1 | At least one operand is NaN |

## Verification
The hardest cases to reach from the ports are the narrow encodings. Uniform random words almost never produce a zero exponent with a non-zero fraction, an infinity, or a pair that shares both sign and exponent. Without such pairs, the fraction tie-break and the reversed order of negative values would go unexercised. The random generator therefore draws the exponent from a weighted set that favours 0, 255 and values near the other operand. It also often derives the second operand from the first by flipping a sign bit or a few low bits, and directed pairs add signed zeros, quiet and signalling NaNs, and infinity against the largest finite value.

// File: rtl/fcmp_pkg.sv
// Shared types for the float comparator.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package fcmp_pkg;

    // Outcome of an unsigned magnitude compare.
    typedef enum logic [1:0] {
        REL_LT = 2'd0,
        REL_EQ = 2'd1,
        REL_GT = 2'd2
    } rel_e;

    // The four result flags, kept together.
    typedef struct packed {
        logic unord;
        logic lt;
        logic eq;
        logic gt;
    } fcmp_flags_t;

    // Reverse an ordering, used when both operands are negative.
    function automatic rel_e rel_flip(input rel_e r);
        case (r)
            REL_LT:  rel_flip = REL_GT;
            REL_GT:  rel_flip = REL_LT;
            default: rel_flip = REL_EQ;
        endcase
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
// Operand classifier.
// Splits one packed float word into a canonical sign and magnitude and flags NaN.
// A zero exponent field means zero, so the word is forced to sign 0, magnitude 0.
// Assumes: the word is sign | exponent | fraction, MSB first.
module fcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              sgn,
    output logic [MAG_W-1:0]  mag,
    output logic              is_nan
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              zero_f;

    assign exp_f  = word[WORD_W-2 -: EXP_W];
    assign frac_f = word[FRAC_W-1:0];

    // Detect the reserved exponent codes.
    always_comb begin
        zero_f = (exp_f == '0);
        is_nan = (exp_f == '1) && (frac_f != '0);
    end

    // Produce the canonical sign and magnitude fed to the ordering logic.
    always_comb begin
        if (zero_f) begin
            sgn = 1'b0;
            mag = '0;
        end else begin
            sgn = word[WORD_W-1];
            mag = word[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/fcmp_magcmp.sv
// Unsigned magnitude comparator built from equal-width slices.
// Each slice compares its bits on its own. The most significant slice that differs decides.
// Assumes: CHUNK_W >= 1; the operands are zero-padded up to a whole number of slices.
module fcmp_magcmp
    import fcmp_pkg::*;
#(
    parameter int MAG_W   = 31,
    parameter int CHUNK_W = 8
) (
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output rel_e             rel
);

    localparam int NCHUNK = (MAG_W + CHUNK_W - 1) / CHUNK_W;
    localparam int PAD_W  = NCHUNK * CHUNK_W;

    logic [PAD_W-1:0]  pa;
    logic [PAD_W-1:0]  pb;
    logic [NCHUNK-1:0] ch_gt;
    logic [NCHUNK-1:0] ch_eq;

    assign pa = PAD_W'(mag_a);
    assign pb = PAD_W'(mag_b);

    // One local compare per slice.
    for (genvar k = 0; k < NCHUNK; k++) begin : g_slice
        logic [CHUNK_W-1:0] sa;
        logic [CHUNK_W-1:0] sb;
        assign sa       = pa[k*CHUNK_W +: CHUNK_W];
        assign sb       = pb[k*CHUNK_W +: CHUNK_W];
        assign ch_gt[k] = (sa > sb);
        assign ch_eq[k] = (sa == sb);
    end

    // Walk upward so the highest unequal slice has the last word.
    always_comb begin
        rel = REL_EQ;
        for (int k = 0; k < NCHUNK; k++) begin
            if (!ch_eq[k]) begin
                rel = ch_gt[k] ? REL_GT : REL_LT;
            end
        end
    end

endmodule

// File: rtl/fcmp_resolve.sv
// Result resolver.
// Combines the canonical signs, NaN flags and the magnitude order into the four flags.
// Assumes: zero operands arrive already canonical (sign 0, magnitude 0).
module fcmp_resolve
    import fcmp_pkg::*;
(
    input  logic        sgn_a,
    input  logic        sgn_b,
    input  logic        nan_a,
    input  logic        nan_b,
    input  rel_e        mag_rel,
    output fcmp_flags_t flags
);

    rel_e signed_rel;

    // Pick the ordering from the signs, reversing it for two negatives.
    always_comb begin
        if (sgn_a != sgn_b) begin
            signed_rel = sgn_a ? REL_LT : REL_GT;
        end else if (sgn_a) begin
            signed_rel = rel_flip(mag_rel);
        end else begin
            signed_rel = mag_rel;
        end
    end

    // Turn the ordering into flags; NaN overrides everything.
    always_comb begin
        flags = '0;
        if (nan_a || nan_b) begin
            flags.unord = 1'b1;
        end else begin
            flags.lt = (signed_rel == REL_LT);
            flags.eq = (signed_rel == REL_EQ);
            flags.gt = (signed_rel == REL_GT);
        end
    end

endmodule

// File: rtl/fcmp_top.sv
// Float comparator top.
// Classifies both operands, compares the magnitudes and registers the flags on the strobe.
// Assumes: the inputs are stable around the clock edge at which in_vld is high.
// The flags hold between strobes.
module fcmp_top
    import fcmp_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int CHUNK_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [EXP_W+FRAC_W:0]       opa,
    input  logic [EXP_W+FRAC_W:0]       opb,
    output logic                        out_vld,
    output logic                        lt,
    output logic                        eq,
    output logic                        gt,
    output logic                        unord
);

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int NOPS   = 2;

    logic [WORD_W-1:0] op_w   [NOPS];
    logic              op_sgn [NOPS];
    logic [MAG_W-1:0]  op_mag [NOPS];
    logic              op_nan [NOPS];

    rel_e        mag_rel;
    fcmp_flags_t nxt_flags;
    fcmp_flags_t flags_q;

    assign op_w[0] = opa;
    assign op_w[1] = opb;

    // Identical classifier per operand.
    for (genvar i = 0; i < NOPS; i++) begin : g_op
        fcmp_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .word   (op_w[i]),
            .sgn    (op_sgn[i]),
            .mag    (op_mag[i]),
            .is_nan (op_nan[i])
        );
    end

    fcmp_magcmp #(
        .MAG_W   (MAG_W),
        .CHUNK_W (CHUNK_W)
    ) u_mag (
        .mag_a (op_mag[0]),
        .mag_b (op_mag[1]),
        .rel   (mag_rel)
    );

    fcmp_resolve u_res (
        .sgn_a   (op_sgn[0]),
        .sgn_b   (op_sgn[1]),
        .nan_a   (op_nan[0]),
        .nan_b   (op_nan[1]),
        .mag_rel (mag_rel),
        .flags   (nxt_flags)
    );

    // Output register: strobe follows in_vld, flags load only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            flags_q <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                flags_q <= nxt_flags;
            end
        end
    end

    assign lt    = flags_q.lt;
    assign eq    = flags_q.eq;
    assign gt    = flags_q.gt;
    assign unord = flags_q.unord;

endmodule

// File: rtl/fcmp_chk.sv
// Property checker for fcmp_top, attached by bind below.
// Derives operand classes straight from the port words.
module fcmp_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic              out_vld,
    input logic              lt,
    input logic              eq,
    input logic              gt,
    input logic              unord
);

    logic nan_a, nan_b, zero_a, zero_b;

    // Port-level operand classes.
    always_comb begin
        nan_a  = (opa[WORD_W-2 -: EXP_W] == '1) && (opa[FRAC_W-1:0] != '0);
        nan_b  = (opb[WORD_W-2 -: EXP_W] == '1) && (opb[FRAC_W-1:0] != '0);
        zero_a = (opa[WORD_W-2 -: EXP_W] == '0);
        zero_b = (opb[WORD_W-2 -: EXP_W] == '0);
    end

    assert_neg_below_pos_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && opa[WORD_W-1] && !opb[WORD_W-1] && !zero_a && !nan_a && !nan_b |=> lt);

    assert_zero_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && zero_a && zero_b |=> eq);

    assert_nan_unord_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && (nan_a || nan_b) |=> unord && !lt && !eq && !gt);

    assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $countones({lt, eq, gt, unord}) == 1);

    assert_strobe_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    assert_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    assert_hold_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable({lt, eq, gt, unord}));

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> !out_vld && !lt && !eq && !gt && !unord);

    assert_self_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && (opa == opb) && !nan_a |=> eq);

endmodule

bind fcmp_top fcmp_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_chk (.*);

// File: tb/sim_fcmp_top.sv
`timescale 1ns/1ps
module sim_fcmp_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [31:0] opa, opb;
    logic        out_vld, lt, eq, gt, unord;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fcmp_top u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
        .out_vld(out_vld), .lt(lt), .eq(eq), .gt(gt), .unord(unord)
    );

    // Value key: zero maps to 0, negatives to minus their magnitude.
    function automatic longint fkey(input logic [31:0] w);
        if (w[30:23] == 8'd0) return 0;
        return w[31] ? -longint'(w[30:0]) : longint'(w[30:0]);
    endfunction

    function automatic bit fnan(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    // Expected flags as {unord, lt, eq, gt}.
    function automatic logic [3:0] ref_flags(input logic [31:0] a, input logic [31:0] b);
        if (fnan(a) || fnan(b)) return 4'b1000;
        if (fkey(a) < fkey(b)) return 4'b0100;
        if (fkey(a) == fkey(b)) return 4'b0010;
        return 4'b0001;
    endfunction

    // Which requirement a pair mainly exercises.
    function automatic string tag_of(input logic [31:0] a, input logic [31:0] b);
        if (fnan(a) || fnan(b)) return "R5";
        if (a == b) return "R10";
        if (a[30:23] == 0 || b[30:23] == 0) return "R4";
        if (a[31] != b[31]) return "R1";
        if (a[31]) return "R3";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, expv);
        end
    endtask

    // Strobe one pair, then check strobe and flags one cycle later.
    task automatic cmp(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        opa = a; opb = b; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check(tag_of(a, b), {out_vld, unord, lt, eq, gt}, {1'b1, ref_flags(a, b)});
    endtask

    // Idle cycle with changed operands: flags must not move (R8), strobe low (R7).
    task automatic idle_check(input logic [31:0] a, input logic [31:0] b);
        logic [3:0] held;
        held = {unord, lt, eq, gt};
        opa = a; opb = b; in_vld = 1'b0;
        @(negedge clk);
        check("R8", {out_vld, unord, lt, eq, gt}, {1'b0, held});
    endtask

    function automatic logic [31:0] rnd_word(input logic [31:0] other);
        logic [31:0] w = $urandom;
        case ($urandom % 8)
            0: w[30:23] = 8'h00;
            1: begin w[30:23] = 8'hFF; w[22:0] = 0; end
            2: begin w[30:23] = 8'hFF; w[22:0] = ($urandom % 4) + 1; end
            3: w[30:23] = other[30:23] + 8'($urandom % 3);
            4: w = other ^ (32'($urandom % 8));
            5: w = other ^ 32'h8000_0000;
            default: ;
        endcase
        return w;
    endfunction

    initial begin
        void'($urandom(32'h1234_5678));
        rst_n = 1'b0; in_vld = 1'b1; opa = 32'h3F80_0000; opb = 32'h4000_0000;
        repeat (3) @(negedge clk);
        check("R9", {out_vld, unord, lt, eq, gt}, 5'b0);
        in_vld = 1'b0;
        rst_n = 1'b1;

        cmp(32'h3F80_0000, 32'h4000_0000);   // R2: 1.0 < 2.0 by exponent
        idle_check(32'h4000_0000, 32'h3F80_0000);
        cmp(32'h3F80_0001, 32'h3F80_0000);   // R2: fraction tie-break
        cmp(32'hBF80_0000, 32'hC000_0000);   // R3: -1 > -2
        cmp(32'hBF80_0000, 32'hBF80_0001);   // R3: reversed fraction order
        cmp(32'hBF80_0000, 32'h3F00_0000);   // R1: negative below positive
        cmp(32'h0000_0000, 32'h8000_0000);   // R4: +0 == -0
        cmp(32'h0000_0001, 32'h8040_0000);   // R4: zero exponent is zero
        cmp(32'h0000_0000, 32'hBF80_0000);   // R4: zero above negative
        cmp(32'h8000_0000, 32'h0080_0000);   // R4: zero below positive
        cmp(32'h7F80_0000, 32'h7F7F_FFFF);   // R5: +inf above max finite
        cmp(32'hFF80_0000, 32'hFF7F_FFFF);   // R5: -inf below -max
        cmp(32'h7FC0_0000, 32'h3F80_0000);   // R5: quiet NaN
        cmp(32'h3F80_0000, 32'hFF80_0001);   // R5: signalling NaN on b
        idle_check(32'h0, 32'h0);
        cmp(32'h4049_0FDB, 32'h4049_0FDB);   // R10: identical words
        cmp(32'hC049_0FDB, 32'hC049_0FDB);   // R10

        for (int i = 0; i < 400; i++) begin
            logic [31:0] a, b;
            a = rnd_word($urandom);
            b = rnd_word(a);
            cmp(a, b);
            if (i % 16 == 0) idle_check($urandom, $urandom);
        end

        // Reset during operation clears results (R9).
        cmp(32'h3F80_0000, 32'h3F80_0000);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", {out_vld, unord, lt, eq, gt}, 5'b0);
        rst_n = 1'b1;
        cmp(32'h4000_0000, 32'h3F80_0000);   // R6: single flag after reset

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule